// File: doc/BRIEF.md
# Transmit Command Header Framer

This block sits in front of a bulk transport and prepares one Ethernet frame at a time for sending. A frame starts with a byte count offered on a length handshake. The payload bytes then arrive on a byte stream handshake. Before any payload byte leaves, the block sends an eight-byte prefix made of two 32-bit command words. Each word is sent least significant byte first, and the first word goes before the second. The first word holds the byte count and two marker bits: one for "starts a segment" and one for "ends a segment". Each frame is one buffer, so both markers are always set. The second word repeats the byte count. After the prefix, the payload passes through unchanged.

The byte count is checked against `MAX_FRAME` at the moment it is accepted. An oversize frame produces no output at all and raises a one-cycle reject pulse. Its payload bytes are then consumed and discarded, so the next frame starts at the right byte of the input stream. The output side is a one-entry register stage with a valid/ready handshake. It holds its byte under backpressure and never loses or repeats one. A new length is taken only after every byte of the current frame has been handed to that output stage, or drained for a rejected frame.

Top module: `txhdr_framer`

## Requirements
- R1: Output bytes 0 to 3 of an accepted frame are the first command word, least significant byte first. That word holds the length N in bits [LEN_W-1:0], has bit 13 (segment start) and bit 12 (segment end) both set, and has every other bit zero. For example, N = 5 gives bytes 05 30 00 00.
- R2: Output bytes 4 to 7 are the second command word, least significant byte first. That word holds N, zero-extended to 32 bits.
- R3: The N payload bytes follow the prefix in input order and unaltered, so an accepted frame is exactly N+8 output bytes. `out_last` is high only on the final byte of the frame. For N = 0, that is prefix byte 7.
- R4: A length greater than `MAX_FRAME` makes the frame rejected. No output byte is produced for it, and `reject` is high for exactly the one cycle in which that length is accepted.
- R5: For a rejected frame of length N, `in_ready` is high and the next N input bytes are consumed and discarded. The following frame's output is then correctly aligned.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values into the next cycle.
- R7: `len_ready` is low from the cycle after a length is accepted until the last byte of that frame has been taken. `in_ready` is low whenever no frame is in progress, so bytes offered then are not consumed.
- R8: After reset, `out_valid` is 0, `len_ready` is 1, `in_ready` is 0 and `reject` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_valid | input | 1 | Frame length offered |
| len_ready | output | 1 | Block can take a new frame length |
| len_bytes | input | LEN_W | Frame payload byte count |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken this cycle |
| in_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte (prefix or payload) |
| out_last | output | 1 | Final byte of a frame |
| reject | output | 1 | One-cycle pulse for an oversize frame |

## Verification
The stimulus mixes several kinds of frame length. Zero length shows whether the prefix alone closes the frame. One byte and exactly `MAX_FRAME` probe the bounds of an accepted frame. `MAX_FRAME`+1 and the largest value the length field can hold must both be rejected and drained. Random short and long lengths in between exercise the normal path. Downstream readiness cycles per frame through always ready, about half the time, and about a quarter of the time. Input gaps are random. Together these show that bytes are held, not dropped or repeated, when the prefix or the payload stalls. A rejected frame placed between accepted frames makes any drain count error appear as a shifted byte in the next frame's expected stream.

// File: rtl/txhdr_pkg.sv
package txhdr_pkg;

    localparam int HDR_BYTES  = 8;
    localparam int SEG_START  = 13;
    localparam int SEG_END    = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_DRAIN
    } txh_state_e;

    // which = 0: first command word (length plus segment markers)
    // which = 1: second command word (length only)
    function automatic logic [31:0] cmd_word(input logic which, input logic [15:0] len);
        logic [31:0] w;
        w = {16'h0000, len};
        if (!which) begin
            w[SEG_START] = 1'b1;
            w[SEG_END]   = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/txhdr_hdr_sel.sv
module txhdr_hdr_sel #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [2:0]       byte_idx,
    output logic [7:0]       hdr_byte
);
    import txhdr_pkg::*;

    localparam int WORDS = HDR_BYTES / 4;

    logic [31:0] words [WORDS];
    logic [7:0]  bytes [HDR_BYTES];

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign words[w] = cmd_word(w[0], 16'(frame_len));
        end
        for (genvar b = 0; b < HDR_BYTES; b++) begin : g_byte
            assign bytes[b] = words[b / 4][8 * (b % 4) +: 8];
        end
    endgenerate

    assign hdr_byte = bytes[byte_idx];

endmodule

// File: rtl/txhdr_ctrl.sv
module txhdr_ctrl #(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_valid,
    output logic             len_ready,
    input  logic [LEN_W-1:0] len_bytes,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             stage_ready,
    input  logic [7:0]       hdr_byte,
    output logic             emit_valid,
    output logic [7:0]       emit_data,
    output logic             emit_last,
    output logic             reject,
    output logic [LEN_W-1:0] frame_len,
    output logic [2:0]       byte_idx
);
    import txhdr_pkg::*;

    localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
    localparam logic [2:0]       HDR_LAST = 3'(HDR_BYTES - 1);

    typedef struct packed {
        txh_state_e       state;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic [2:0]       idx;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        len_ready  = 1'b0;
        in_ready   = 1'b0;
        reject     = 1'b0;
        emit_valid = 1'b0;
        emit_data  = hdr_byte;
        emit_last  = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                len_ready = 1'b1;
                if (len_valid) begin
                    ctl_d.len = len_bytes;
                    ctl_d.cnt = len_bytes;
                    ctl_d.idx = 3'd0;
                    if (32'(len_bytes) > 32'(MAX_FRAME)) begin
                        reject      = 1'b1;
                        ctl_d.state = ST_DRAIN;
                    end else begin
                        ctl_d.state = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                emit_valid = 1'b1;
                emit_last  = (ctl_q.idx == HDR_LAST) && (ctl_q.len == '0);
                if (stage_ready) begin
                    ctl_d.idx = ctl_q.idx + 3'd1;
                    if (ctl_q.idx == HDR_LAST) begin
                        ctl_d.state = (ctl_q.len == '0) ? ST_IDLE : ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                in_ready   = stage_ready;
                emit_valid = in_valid;
                emit_data  = in_data;
                emit_last  = (ctl_q.cnt == ONE);
                if (in_valid && stage_ready) begin
                    ctl_d.cnt = ctl_q.cnt - ONE;
                    if (ctl_q.cnt == ONE) begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
            default: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ctl_d.cnt = ctl_q.cnt - ONE;
                    if (ctl_q.cnt == ONE) begin
                        ctl_d.state = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, len: '0, cnt: '0, idx: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign frame_len = ctl_q.len;
    assign byte_idx  = ctl_q.idx;

endmodule

// File: rtl/txhdr_outstage.sv
module txhdr_outstage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_valid,
    output logic       up_ready,
    input  logic [7:0] up_data,
    input  logic       up_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);
    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       last;
    } stage_s;

    stage_s stg_d, stg_q;

    always_comb begin
        stg_d    = stg_q;
        up_ready = !stg_q.valid || out_ready;
        if (out_ready) begin
            stg_d.valid = 1'b0;
        end
        if (up_valid && up_ready) begin
            stg_d.valid = 1'b1;
            stg_d.data  = up_data;
            stg_d.last  = up_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '{valid: 1'b0, data: 8'h00, last: 1'b0};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign out_valid = stg_q.valid;
    assign out_data  = stg_q.data;
    assign out_last  = stg_q.last;

endmodule

// File: rtl/txhdr_framer.sv
module txhdr_framer #(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_valid,
    output logic             len_ready,
    input  logic [LEN_W-1:0] len_bytes,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             reject
);
    logic             stage_ready;
    logic             emit_valid;
    logic [7:0]       emit_data;
    logic             emit_last;
    logic [7:0]       hdr_byte;
    logic [LEN_W-1:0] frame_len;
    logic [2:0]       byte_idx;

    txhdr_ctrl #(
        .LEN_W     (LEN_W),
        .MAX_FRAME (MAX_FRAME)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_valid   (len_valid),
        .len_ready   (len_ready),
        .len_bytes   (len_bytes),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .stage_ready (stage_ready),
        .hdr_byte    (hdr_byte),
        .emit_valid  (emit_valid),
        .emit_data   (emit_data),
        .emit_last   (emit_last),
        .reject      (reject),
        .frame_len   (frame_len),
        .byte_idx    (byte_idx)
    );

    txhdr_hdr_sel #(
        .LEN_W (LEN_W)
    ) u_hdr (
        .frame_len (frame_len),
        .byte_idx  (byte_idx),
        .hdr_byte  (hdr_byte)
    );

    txhdr_outstage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_valid  (emit_valid),
        .up_ready  (stage_ready),
        .up_data   (emit_data),
        .up_last   (emit_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/txhdr_framer_chk.sv
module txhdr_framer_chk #(
    parameter int LEN_W     = 11,
    parameter int MAX_FRAME = 1514
) (
    input logic             clk,
    input logic             rst_n,
    input logic             len_valid,
    input logic             len_ready,
    input logic [LEN_W-1:0] len_bytes,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             reject
);
    logic [15:0] ocnt;
    logic [15:0] pend_len;
    logic [15:0] cur_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ocnt     <= 16'd0;
            pend_len <= 16'd0;
            cur_len  <= 16'd0;
        end else begin
            if (len_valid && len_ready && !reject) begin
                pend_len <= 16'(len_bytes);
            end
            if (out_valid && out_ready) begin
                ocnt <= out_last ? 16'd0 : ocnt + 16'd1;
                if (ocnt == 16'd0) begin
                    cur_len <= pend_len;
                end
            end
        end
    end

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

    AST_REJ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject); // R4

    AST_REJ_HOLDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !len_ready); // R7

    AST_IDLE_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
        len_ready |-> !in_ready); // R7

    AST_FIRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (ocnt == 16'd0) |-> out_data == pend_len[7:0]); // R1

    AST_SEG_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (ocnt == 16'd1) |-> out_data[5:4] == 2'b11); // R1

    AST_FRAME_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last && (ocnt != 16'd0) |-> ocnt == cur_len + 16'd7); // R3

endmodule

bind txhdr_framer txhdr_framer_chk #(
    .LEN_W     (LEN_W),
    .MAX_FRAME (MAX_FRAME)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_valid (len_valid),
    .len_ready (len_ready),
    .len_bytes (len_bytes),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .reject    (reject)
);

// File: tb/txhdr_framer_test.sv
module txhdr_framer_test;
    localparam int LEN_W     = 11;
    localparam int MAX_FRAME = 1514;
    localparam int LEN_TOP   = (1 << LEN_W) - 1;
    localparam int NFR       = 40;
    localparam int WDOG      = 190000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             len_valid = 1'b0;
    logic             len_ready;
    logic [LEN_W-1:0] len_bytes = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = 8'h00;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic             out_last;
    logic             reject;

    always #4 clk = ~clk;

    txhdr_framer #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) uut (
        .clk(clk), .rst_n(rst_n),
        .len_valid(len_valid), .len_ready(len_ready), .len_bytes(len_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .reject(reject)
    );

    int checks = 0;
    int errors = 0;
    int flen [NFR];
    logic [8:0] exp_q [$];
    int         tag_q [$];
    int exp_rej = 0;
    int seen_rej = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_byte(input int fi, input int bi);
        return 8'(fi * 29 + bi * 7 + (bi >> 3)) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] hdr_byte(input int len, input int i);
        logic [31:0] w0;
        logic [31:0] w1;
        w0 = 32'(len) | 32'h0000_3000;
        w1 = 32'(len);
        return (i < 4) ? 8'(w0 >> (8 * i)) : 8'(w1 >> (8 * (i - 4)));
    endfunction

    function automatic string tag_name(input int t);
        return (t == 1) ? "R1" : (t == 2) ? "R2" : "R3";
    endfunction

    initial begin
        int fi;
        int bi;
        int phase;
        int cyc;
        bit prev_stall;
        logic [7:0] prev_d;
        logic prev_l;
        logic [8:0] e;
        int t;
        bit exp_pulse;

        void'($urandom(20240611));
        flen[0] = 0;
        flen[1] = 1;
        flen[2] = MAX_FRAME;
        flen[3] = MAX_FRAME + 1;
        flen[4] = 5;
        flen[5] = LEN_TOP;
        flen[6] = 2;
        for (int k = 7; k < NFR; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0)      flen[k] = $urandom_range(MAX_FRAME + 1, MAX_FRAME + 40);
            else if (r == 1) flen[k] = $urandom_range(400, MAX_FRAME);
            else             flen[k] = $urandom_range(0, 64);
        end
        for (int k = 0; k < NFR; k++) begin
            if (flen[k] > MAX_FRAME) begin
                exp_rej++;
            end else begin
                for (int i = 0; i < 8; i++) begin
                    exp_q.push_back({(flen[k] == 0 && i == 7), hdr_byte(flen[k], i)});
                    tag_q.push_back(i < 4 ? 1 : 2);
                end
                for (int i = 0; i < flen[k]; i++) begin
                    exp_q.push_back({(i == flen[k] - 1), pay_byte(k, i)});
                    tag_q.push_back(3);
                end
            end
        end

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        chk(len_ready == 1'b1, "R8", int'(len_ready), 1);
        chk(in_ready == 1'b0, "R8", int'(in_ready), 0);
        chk(reject == 1'b0, "R8", int'(reject), 0);

        // Bytes offered with no frame in progress must be left alone
        in_valid  = 1'b1;
        in_data   = 8'hEE;
        out_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(in_ready == 1'b0, "R7 idle in_ready", int'(in_ready), 0);
            chk(out_valid == 1'b0, "R7 idle output", int'(out_valid), 0);
        end
        in_valid = 1'b0;

        fi = 0; bi = 0; phase = 0; cyc = 0; prev_stall = 0;
        prev_d = 8'h00; prev_l = 1'b0;
        while (!(fi >= NFR && exp_q.size() == 0) && cyc < WDOG) begin
            @(negedge clk);
            cyc++;
            if (prev_stall) begin
                chk(out_valid && out_data == prev_d && out_last == prev_l, "R6 hold",
                    {out_valid, out_last, out_data}, {1'b1, prev_l, prev_d});
            end
            len_valid = (phase == 0 && fi < NFR) ? ($urandom_range(0, 3) != 0) : 1'b0;
            len_bytes = (fi < NFR) ? LEN_W'(flen[fi]) : '0;
            in_valid  = (phase == 1) ? ((fi % 2 == 0) || ($urandom_range(0, 3) != 0)) : 1'b0;
            in_data   = (fi < NFR) ? pay_byte(fi, bi) : 8'h00;
            case (fi % 3)
                0:       out_ready = 1'b1;
                1:       out_ready = ($urandom_range(0, 1) == 0);
                default: out_ready = ($urandom_range(0, 3) == 0);
            endcase
            #1;
            if (phase == 1) begin
                chk(len_ready == 1'b0, "R7 busy len_ready", int'(len_ready), 0);
                if (flen[fi] > MAX_FRAME && in_valid) begin
                    chk(in_ready == 1'b1, "R5 drain", int'(in_ready), 1);
                end
            end
            exp_pulse = len_valid && len_ready && (flen[fi] > MAX_FRAME);
            if (reject || exp_pulse) begin
                chk(reject == exp_pulse, "R4 reject", int'(reject), int'(exp_pulse));
            end
            if (reject) seen_rej++;
            if (len_valid && len_ready) begin
                if (flen[fi] == 0) begin
                    fi++;
                end else begin
                    phase = 1;
                    bi = 0;
                end
            end else if (in_valid && in_ready) begin
                bi++;
                if (bi == flen[fi]) begin
                    phase = 0;
                    fi++;
                end
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected output", int'(out_data), 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_data == e[7:0], tag_name(t), int'(out_data), int'(e[7:0]));
                    chk(out_last == e[8], "R3 last", int'(out_last), int'(e[8]));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_l = out_last;
        end
        len_valid = 1'b0;
        in_valid  = 1'b0;
        if (cyc >= WDOG) begin
            chk(1'b0, "watchdog", cyc, WDOG);
        end
        repeat (4) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R3 no extra output", int'(out_valid), 0);
        chk(exp_q.size() == 0, "R3 stream complete", exp_q.size(), 0);
        chk(seen_rej == exp_rej, "R4 reject count", seen_rej, exp_rej);
        chk(len_ready == 1'b1, "R5 aligned at end", int'(len_ready), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule